// File: doc/BRIEF.md
# LIN Bus Remote Wake-up Qualifier

This block decides when activity on a LIN bus should pull a sleeping transceiver out of its lowest-power state. Its input is the digital output of a low-voltage comparator on the bus line, which reads 1 while the bus sits below the wake threshold. The comparator bit may change at any time relative to the clock, so it first passes through a two-stage synchronizer.

The detector runs only while the arm level from the power controller is high. Once armed, it counts consecutive clock cycles in which the synchronized bus reads low. A low phase is qualified once that count reaches a programmable cycle limit. For example, a limit of about 80 µs divided by the clock period lets a LIN break character qualify. A qualified low phase produces no output until the bus rises again. On that rising edge the block emits a one-cycle wake pulse, which asks the controller to bring the device up into its ready state. If the bus goes high before the limit is reached, the count is discarded. After one wake the detector stays quiet until the arm level drops and is raised again.

Top module: `lin_wake_detect`

## Requirements
- R1: While reset is asserted, and afterwards until the block is armed, wake_o is 0.
- R2: While arm_i is 0 the detector produces no wake, whatever bus_low_i does.
- R3: bus_low_i passes through two synchronizer flops. A wake pulse is on wake_o after the third rising clock edge following the cycle in which the raw bus input returned to 0.
- R4: When armed, bus_low_i held at 1 for at least qual_cycles_i consecutive clock cycles and then returned to 0 produces a wake pulse.
- R5: A low phase of fewer than qual_cycles_i cycles produces no wake. Any single cycle with bus_low_i at 0 clears the count, so two short low phases never add up.
- R6: No wake is produced while the bus is still low, however long the low phase lasts. The wake comes only on the return to 0.
- R7: The wake pulse on wake_o lasts exactly one clock cycle.
- R8: After a wake, no further wake occurs until arm_i has gone to 0 and back to 1.
- R9: A qual_cycles_i value of 0 is treated as 1.
- R10: Dropping arm_i after a low phase has qualified, but before the bus rises, cancels the pending wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Detector clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | High while the transceiver is in its power-down state; enables detection |
| bus_low_i | input | 1 | Asynchronous comparator bit; 1 means the bus is below the wake threshold |
| qual_cycles_i | input | CNT_W (16) | Minimum low-phase length in clock cycles |
| wake_o | output | 1 | One-cycle remote wake request |

## Verification
On every cycle the assertions enforce the single-cycle pulse width, the absence of wakes while disarmed, the one-wake-per-arming rule, and that a wake is always preceded by the raw bus having been high three edges earlier. Whether the low phase was long enough cannot be seen in any one cycle. The same holds for clearing the count on an interrupted low phase, for the treatment of a zero limit, and for cancellation by disarming in the qualified state. The bench's scenarios cover these, including low phases of exactly the limit and one cycle short of it.

// File: rtl/lwd_pkg.sv
package lwd_pkg;

    typedef enum logic [2:0] {
        ST_OFF,      // disarmed
        ST_LISTEN,   // armed, bus high, count empty
        ST_COUNT,    // counting a low phase
        ST_ARMED,    // low phase qualified, waiting for the rise
        ST_SPENT     // wake issued, waiting for disarm
    } lwd_state_e;

endpackage

// File: rtl/lwd_sync.sv
module lwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lwd_fsm.sv
module lwd_fsm
    import lwd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             arm_i,
    input  logic             low_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             wake_o
);
    typedef struct packed {
        lwd_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             wake;
    } regs_t;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    regs_t r_q, r_d;
    logic [CNT_W-1:0] limit_eff;
    logic [CNT_W-1:0] bump;

    always_comb begin
        limit_eff = (limit_i == '0) ? CNT_ONE : limit_i;
        bump      = (r_q.cnt == CNT_MAX) ? r_q.cnt : r_q.cnt + CNT_ONE;

        r_d      = r_q;
        r_d.wake = 1'b0;

        unique case (r_q.state)
            ST_OFF: begin
                r_d.cnt = '0;
                if (arm_i) r_d.state = ST_LISTEN;
            end
            ST_LISTEN, ST_COUNT: begin
                if (low_i) begin
                    r_d.cnt   = bump;
                    r_d.state = (bump >= limit_eff) ? ST_ARMED : ST_COUNT;
                end else begin
                    r_d.cnt   = '0;
                    r_d.state = ST_LISTEN;
                end
            end
            ST_ARMED: begin
                if (!low_i) begin
                    r_d.wake  = 1'b1;
                    r_d.state = ST_SPENT;
                end
            end
            ST_SPENT: begin
                r_d.cnt = '0;
            end
            default: begin
                r_d.state = ST_OFF;
                r_d.cnt   = '0;
            end
        endcase

        if (!arm_i) begin
            r_d.state = ST_OFF;
            r_d.cnt   = '0;
            r_d.wake  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state <= ST_OFF;
            r_q.cnt   <= '0;
            r_q.wake  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wake_o = r_q.wake;
endmodule

// File: rtl/lin_wake_detect.sv
module lin_wake_detect #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             arm_i,
    input  logic             bus_low_i,
    input  logic [CNT_W-1:0] qual_cycles_i,
    output logic             wake_o
);
    logic low_sync;

    lwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (bus_low_i),
        .q_o   (low_sync)
    );

    lwd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .arm_i  (arm_i),
        .low_i  (low_sync),
        .limit_i(qual_cycles_i),
        .wake_o (wake_o)
    );
endmodule

// File: rtl/lwd_checker.sv
module lwd_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic arm_i,
    input logic bus_low_i,
    input logic wake_o
);
    logic fired_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     fired_q <= 1'b0;
        else if (!arm_i) fired_q <= 1'b0;
        else if (wake_o) fired_q <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |=> !wake_o);

    // R7
    wake_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |=> !wake_o);

    // R2
    disarmed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_i |=> !wake_o);

    // R8
    single_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> !fired_q);

    // R3
    rise_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> !$past(bus_low_i, 3));
endmodule

bind lin_wake_detect lwd_checker u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_i),
    .bus_low_i(bus_low_i),
    .wake_o   (wake_o)
);

// File: tb/sim_lin_wake_detect.sv
module sim_lin_wake_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        bus_low = 1'b0;
    logic [15:0] qual = 16'd8;
    logic        wake;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    lin_wake_detect u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .arm_i        (arm),
        .bus_low_i    (bus_low),
        .qual_cycles_i(qual),
        .wake_o       (wake)
    );

    localparam int NV = 9;
    localparam int V_LEN  [NV] = '{8, 7, 1, 1, 20, 3, 5, 40, 29};
    localparam int V_QUAL [NV] = '{8, 8, 1, 0,  8, 5, 5, 30, 30};
    localparam int V_EXP  [NV] = '{1, 0, 1, 1,  1, 0, 1,  1,  0};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // watch the output for n negedges; returns count of wake cycles and last index seen
    task automatic watch(input int n, output int seen, output int at);
        seen = 0;
        at = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (wake) begin
                seen++;
                at = k;
            end
        end
    endtask

    task automatic rearm();
        arm = 1'b0;
        repeat (3) @(negedge clk);
        arm = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_case(input int len, input int q, input int expv, input string req);
        int s_low, s_rise, at;
        qual = q[15:0];
        rearm();
        bus_low = 1'b1;
        watch(len, s_low, at);
        // R6: nothing while the bus is still low
        check(s_low == 0, "R6", s_low, 0);
        bus_low = 1'b0;
        watch(6, s_rise, at);
        // R3/R7: one pulse, at the third edge after the rise
        check(s_rise == expv && (expv == 0 || at == 3), req, s_rise * 10 + at, expv * 13);
    endtask

    initial begin
        int s, at;
        // R1: quiet in reset
        repeat (3) @(negedge clk);
        check(wake == 1'b0, "R1", int'(wake), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(wake == 1'b0, "R1", int'(wake), 0);

        // R2: bus activity while disarmed
        bus_low = 1'b1;
        watch(20, s, at);
        bus_low = 1'b0;
        begin
            int s2;
            watch(6, s2, at);
            check(s + s2 == 0, "R2", s + s2, 0);
        end

        // table walk: R4 qualified, R5 short, R9 zero limit, R3 latency, R7 width
        for (int i = 0; i < NV; i++) begin
            run_case(V_LEN[i], V_QUAL[i], V_EXP[i],
                     (V_QUAL[i] == 0) ? "R9" : (V_EXP[i] != 0 ? "R4" : "R5"));
        end

        // R8: second qualified low phase without re-arming gives no wake
        qual = 16'd6;
        rearm();
        bus_low = 1'b1; repeat (10) @(negedge clk);
        bus_low = 1'b0; watch(6, s, at);
        check(s == 1, "R8", s, 1);
        bus_low = 1'b1; repeat (10) @(negedge clk);
        bus_low = 1'b0; watch(6, s, at);
        check(s == 0, "R8", s, 0);
        // after arm toggles, wake works again
        run_case(10, 6, 1, "R8");

        // R5: two short low phases split by one high cycle do not add up
        qual = 16'd6;
        rearm();
        bus_low = 1'b1; repeat (5) @(negedge clk);
        bus_low = 1'b0; @(negedge clk);
        bus_low = 1'b1; repeat (5) @(negedge clk);
        bus_low = 1'b0; watch(6, s, at);
        check(s == 0, "R5", s, 0);

        // R10: disarm while qualified, then bus rises
        qual = 16'd4;
        rearm();
        bus_low = 1'b1; repeat (10) @(negedge clk);
        arm = 1'b0; @(negedge clk);
        bus_low = 1'b0; watch(6, s, at);
        check(s == 0, "R10", s, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end
endmodule